// File: doc/BRIEF.md
# Embedded-Clock Serializer Framer

This block converts a stream of 10-bit parallel words into a single serial bit stream. The serial line carries its own timing. Every 12-bit frame begins with a start bit that is always one and ends with a stop bit that is always zero, so a receiver always sees at least one edge per frame and can recover the clock from it. The whole block runs on one fast bit clock. A phase counter splits that clock into parallel-word periods of twelve bit times and publishes the parallel clock as `pclk_o`. The word source uses `pclk_o` to time its data.

A receiver that has lost alignment can ask for a burst of synchronisation symbols on either of two request lines. A request is accepted only after it has stayed high for five consecutive parallel periods. Once accepted, the burst lasts at least a programmable number of symbols and continues for as long as a request stays high. During the burst the parallel data is ignored.

The analog phase-locked loop is replaced by a lock-delay counter. A power-down control stops this counter and the framing logic. An output enable gates the drive without disturbing the internal state. Nothing is driven until the lock delay has elapsed.

Top module: `ser_framer_top`

## Requirements
- R1: One parallel period lasts 12 bit clocks. `pclk_o` is high for the first 6 bit clocks of the period and low for the last 6. Each serial frame starts in the clock where `pclk_o` rises.
- R2: A data frame puts these bits on `ser_o`, one per clock, in this order: a 1 (start bit), then word bits 0 through 9 (least significant bit first), then a 0 (stop bit).
- R3: When `edge_rise_i` is 1, the word is sampled at the end of the parallel period, on the clock edge where `pclk_o` rises. When `edge_rise_i` is 0, the word is sampled at the clock edge where `pclk_o` falls. In both cases the sampled word is sent in the next frame.
- R4: The two request lines are ORed. A request is accepted when it has been high at five consecutive period ends. The frame after the fifth such period end is a sync symbol: six 1s followed by six 0s, so the frame value is 0x03F when bit 0 is sent first. A request that lasts only four periods is ignored.
- R5: An accepted burst lasts at least SYNC_MIN symbols. It keeps going while either request is high. Data frames resume after a symbol that ends with the count reached and both requests low. The data input has no effect during the burst.
- R6: After reset, `ready_o` rises after LOCK_CYCLES parallel periods. `drv_en_o` stays low until `ready_o` is high.
- R7: While `pwr_on_i` is low, `ready_o` and `drv_en_o` are low. When `pwr_on_i` returns high, the full lock delay runs again, and then frames resume.
- R8: While `oe_i` is low, `drv_en_o` is low. The framing and sync state keep running, so after `oe_i` returns high the frames continue in the mode that was in progress.
- R9: `ser_o` is 0 whenever `drv_en_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock (12 times the parallel rate) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | DATA_W | Parallel word |
| edge_rise_i | input | 1 | 1: sample the word where `pclk_o` rises; 0: sample where it falls |
| sync_a_i | input | 1 | Sync request line A |
| sync_b_i | input | 1 | Sync request line B |
| oe_i | input | 1 | Output enable |
| pwr_on_i | input | 1 | 0 puts the block into power-down |
| ser_o | output | 1 | Serial bit |
| drv_en_o | output | 1 | Serial line is being driven |
| ready_o | output | 1 | Lock delay complete |
| pclk_o | output | 1 | Parallel clock derived from the bit clock |

## Verification
Two decisions can fall on the same period end: a sync burst may finish, and the data path may take up a new word for the next frame. The bench provokes this by letting each request drop exactly at a period boundary, both before and after the minimum count is reached. The scoreboard then compares every following frame against a schedule worked out from the counts alone, so a one-frame early or late switch shows up as a wrong frame value. A second clash is an output-enable drop in the middle of a burst. The bench judges it by checking that the drive is silent while enable is low, and that sync symbols are still being sent, in the right number, once enable returns.

// File: rtl/ser_framer_pkg.sv
package ser_framer_pkg;
  typedef enum logic {
    FK_DATA = 1'b0,
    FK_SYNC = 1'b1
  } frame_kind_e;
endpackage

// File: rtl/ser_lock_timer.sv
module ser_lock_timer #(
  parameter int FRAME_W     = 12,
  parameter int LOCK_CYCLES = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwr_on_i,
  output logic frame_end_o,
  output logic mid_end_o,
  output logic pclk_o,
  output logic ready_o
);
  localparam int PH_W = $clog2(FRAME_W);
  localparam int LK_W = $clog2(LOCK_CYCLES + 1);

  logic [PH_W-1:0] ph_q;
  logic [LK_W-1:0] lk_q;
  logic            ready_q;

  assign frame_end_o = (ph_q == PH_W'(FRAME_W - 1));
  assign mid_end_o   = (ph_q == PH_W'(FRAME_W / 2 - 1));
  assign pclk_o      = (ph_q < PH_W'(FRAME_W / 2));
  assign ready_o     = ready_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q    <= '0;
      lk_q    <= '0;
      ready_q <= 1'b0;
    end else if (!pwr_on_i) begin
      ph_q    <= '0;
      lk_q    <= '0;
      ready_q <= 1'b0;
    end else begin
      ph_q <= frame_end_o ? '0 : ph_q + 1'b1;
      if (frame_end_o && !ready_q) begin
        lk_q <= lk_q + 1'b1;
        if (lk_q == LK_W'(LOCK_CYCLES - 1)) ready_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/ser_sync_ctrl.sv
module ser_sync_ctrl
  import ser_framer_pkg::*;
#(
  parameter int SYNC_QUAL = 5,
  parameter int SYNC_MIN  = 1024
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        pwr_on_i,
  input  logic        step_i,
  input  logic        req_i,
  output frame_kind_e kind_o
);
  localparam int QL_W  = $clog2(SYNC_QUAL + 1);
  localparam int SYM_W = $clog2(SYNC_MIN + 1);

  logic [QL_W-1:0]  qual_q, qual_nxt;
  logic [SYM_W-1:0] sym_q;
  logic             act_q, send_sync, min_met;

  assign qual_nxt = !req_i ? '0 :
                    (qual_q == QL_W'(SYNC_QUAL)) ? qual_q : qual_q + 1'b1;
  assign min_met  = (sym_q >= SYM_W'(SYNC_MIN));

  // an active burst ends only on a boundary with count met and no request
  assign send_sync = act_q ? !(min_met && !req_i) : (qual_nxt == QL_W'(SYNC_QUAL));
  assign kind_o    = send_sync ? FK_SYNC : FK_DATA;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      qual_q <= '0;
      sym_q  <= '0;
      act_q  <= 1'b0;
    end else if (!pwr_on_i) begin
      qual_q <= '0;
      sym_q  <= '0;
      act_q  <= 1'b0;
    end else if (step_i) begin
      qual_q <= qual_nxt;
      act_q  <= send_sync;
      if (!send_sync)  sym_q <= '0;
      else if (!act_q) sym_q <= SYM_W'(1);
      else if (!min_met) sym_q <= sym_q + 1'b1;
    end
  end
endmodule

// File: rtl/ser_frame_shift.sv
module ser_frame_shift
  import ser_framer_pkg::*;
#(
  parameter int DATA_W  = 10,
  parameter int FRAME_W = DATA_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwr_on_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              edge_rise_i,
  input  logic              mid_i,
  input  logic              load_i,
  input  frame_kind_e       kind_i,
  output logic              ser_bit_o,
  output logic              run_o
);
  logic [DATA_W-1:0]  hold_q, word;
  logic [FRAME_W-1:0] sreg_q, sync_pat, data_frm;
  logic               run_q;

  for (genvar g = 0; g < FRAME_W; g++) begin : g_sync_pat
    assign sync_pat[g] = (g < FRAME_W / 2);
  end

  assign word      = edge_rise_i ? data_i : hold_q;
  assign data_frm  = {1'b0, word, 1'b1};
  assign ser_bit_o = sreg_q[0];
  assign run_o     = run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      sreg_q <= '0;
      run_q  <= 1'b0;
    end else if (!pwr_on_i) begin
      sreg_q <= '0;
      run_q  <= 1'b0;
    end else begin
      if (mid_i && !edge_rise_i) hold_q <= data_i;
      if (load_i) begin
        sreg_q <= (kind_i == FK_SYNC) ? sync_pat : data_frm;
        run_q  <= 1'b1;
      end else begin
        sreg_q <= {1'b0, sreg_q[FRAME_W-1:1]};
      end
    end
  end
endmodule

// File: rtl/ser_framer_top.sv
module ser_framer_top
  import ser_framer_pkg::*;
#(
  parameter int DATA_W      = 10,
  parameter int LOCK_CYCLES = 1024,
  parameter int SYNC_MIN    = 1024,
  parameter int SYNC_QUAL   = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic              edge_rise_i,
  input  logic              sync_a_i,
  input  logic              sync_b_i,
  input  logic              oe_i,
  input  logic              pwr_on_i,
  output logic              ser_o,
  output logic              drv_en_o,
  output logic              ready_o,
  output logic              pclk_o
);
  localparam int FRAME_W = DATA_W + 2;

  logic        frame_end, mid_end, ready, step, ser_bit, run;
  frame_kind_e kind;

  ser_lock_timer #(.FRAME_W(FRAME_W), .LOCK_CYCLES(LOCK_CYCLES)) u_timer (
    .clk_i, .rst_ni, .pwr_on_i,
    .frame_end_o(frame_end), .mid_end_o(mid_end), .pclk_o(pclk_o), .ready_o(ready)
  );

  assign step = frame_end & ready;

  ser_sync_ctrl #(.SYNC_QUAL(SYNC_QUAL), .SYNC_MIN(SYNC_MIN)) u_sync (
    .clk_i, .rst_ni, .pwr_on_i, .step_i(step),
    .req_i(sync_a_i | sync_b_i), .kind_o(kind)
  );

  ser_frame_shift #(.DATA_W(DATA_W), .FRAME_W(FRAME_W)) u_shift (
    .clk_i, .rst_ni, .pwr_on_i, .data_i, .edge_rise_i,
    .mid_i(mid_end), .load_i(step), .kind_i(kind),
    .ser_bit_o(ser_bit), .run_o(run)
  );

  assign ready_o  = ready;
  assign drv_en_o = run & oe_i & pwr_on_i;
  assign ser_o    = drv_en_o & ser_bit;
endmodule

// File: rtl/ser_framer_chk.sv
module ser_framer_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic pwr_on_i,
  input logic oe_i,
  input logic ser_o,
  input logic drv_en_o,
  input logic ready_o,
  input logic pclk_o,
  input logic frame_end_i
);
  AST_START_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(pclk_o) && drv_en_o) |-> ser_o); // R2
  AST_STOP_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_end_i && drv_en_o) |-> !ser_o); // R2
  AST_NO_DRIVE_UNLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drv_en_o |-> ready_o); // R6
  AST_PWR_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_on_i |=> (!ready_o && !drv_en_o)); // R7
  AST_OE_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_i |-> !drv_en_o); // R8
  AST_QUIET_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !drv_en_o |-> !ser_o); // R9
endmodule

bind ser_framer_top ser_framer_chk chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .pwr_on_i(pwr_on_i), .oe_i(oe_i),
  .ser_o(ser_o), .drv_en_o(drv_en_o), .ready_o(ready_o), .pclk_o(pclk_o),
  .frame_end_i(frame_end)
);

// File: tb/ser_framer_top_tb_top.sv
module ser_framer_top_tb_top;
  localparam int DW = 10;
  localparam int LOCK = 16;
  localparam int SMIN = 8;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [DW-1:0] data_i = '0;
  logic edge_rise_i = 1'b1, sync_a_i = 1'b0, sync_b_i = 1'b0, oe_i = 1'b1, pwr_on_i = 1'b1;
  logic ser_o, drv_en_o, ready_o, pclk_o;

  int checks = 0, errors = 0;

  ser_framer_top #(.DATA_W(DW), .LOCK_CYCLES(LOCK), .SYNC_MIN(SMIN), .SYNC_QUAL(5)) dut_i (
    .clk_i, .rst_ni, .data_i, .edge_rise_i, .sync_a_i, .sync_b_i, .oe_i, .pwr_on_i,
    .ser_o, .drv_en_o, .ready_o, .pclk_o
  );

  always #5 clk_i = ~clk_i;

  logic [11:0] q_f[$];
  string       q_t[$];
  logic [11:0] pend_f;
  string       pend_t;
  bit          pend_v = 0;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic wait_ph0();
    logic p;
    p = pclk_o;
    forever begin
      @(negedge clk_i);
      if (pclk_o && !p) break;
      p = pclk_o;
    end
  endtask

  function automatic logic [11:0] exp_frame(input bit is_sync, input logic [DW-1:0] d);
    return is_sync ? 12'h03F : {1'b0, d, 1'b1};
  endfunction

  // at a frame start: queue the item for this frame, drive inputs for the next
  task automatic step(input logic [DW-1:0] d, input logic ra, input logic rb,
                      input bit push, input bit is_sync, input string tag);
    wait_ph0();
    if (pend_v) begin q_f.push_back(pend_f); q_t.push_back(pend_t); end
    data_i = d; sync_a_i = ra; sync_b_i = rb;
    pend_f = exp_frame(is_sync, d); pend_t = tag; pend_v = push;
  endtask

  task automatic step_split(input logic [DW-1:0] a, input logic [DW-1:0] b, input logic [DW-1:0] e);
    wait_ph0();
    if (pend_v) begin q_f.push_back(pend_f); q_t.push_back(pend_t); end
    data_i = a;
    repeat (8) @(negedge clk_i);
    data_i = b;
    pend_f = exp_frame(0, e); pend_t = "R3"; pend_v = 1;
  endtask

  task automatic drain();
    step('0, 0, 0, 0, 0, "");
    step('0, 0, 0, 0, 0, "");
    wait (q_f.size() == 0);
    @(negedge clk_i);
  endtask

  task automatic lock_wait(input string tag);
    int n;
    bit early;
    logic p;
    n = 0; early = 0; p = pclk_o;
    while (!ready_o) begin
      @(negedge clk_i);
      if (pclk_o && !p) n++;
      p = pclk_o;
      if (!ready_o && drv_en_o) early = 1;
    end
    chk(n == LOCK, tag, "lock periods", n, LOCK);
    chk(!early, "R6", "drive before ready", early, 0);
  endtask

  // monitor: assemble frames aligned to pclk_o rises and compare against the queue
  int          mon_idx = 100;
  logic        mon_p = 1'b1;
  logic [11:0] rx;
  bit          allen;
  always @(negedge clk_i) begin
    if (pclk_o && !mon_p) mon_idx = 0; else mon_idx = mon_idx + 1;
    mon_p = pclk_o;
    if (mon_idx < 12) begin
      if (mon_idx == 0) allen = 1;
      rx[mon_idx] = ser_o;
      if (!drv_en_o) allen = 0;
    end
    if (mon_idx == 11 && q_f.size() > 0) begin
      logic [11:0] f;
      string t;
      f = q_f.pop_front(); t = q_t.pop_front();
      checks++;
      if (!allen || rx != f) begin
        errors++;
        $display("FAIL %s frame: got %h (drive %0d) expected %h", t, rx, allen, f);
      end
    end
  end

  initial begin
    #1_500_000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(!ready_o, "R6", "ready in reset", ready_o, 0);
    chk(!drv_en_o, "R9", "drive in reset", drv_en_o, 0);
    chk(!ser_o, "R9", "line in reset", ser_o, 0);
    rst_ni = 1'b1;
    lock_wait("R6");

    // R1: period shape of pclk_o
    begin
      int hi, tot;
      wait_ph0();
      hi = 1; tot = 1;
      forever begin
        @(negedge clk_i);
        if (pclk_o && tot >= 6) break;
        if (pclk_o) hi++;
        tot++;
      end
      chk(hi == 6, "R1", "pclk high clocks", hi, 6);
      chk(tot == 12, "R1", "period clocks", tot, 12);
    end

    // R2: plain data frames, rising-edge sampling
    step(10'h001, 0, 0, 1, 0, "R2");
    step(10'h3FF, 0, 0, 1, 0, "R2");
    step(10'h2A5, 0, 0, 1, 0, "R2");
    step(10'h000, 0, 0, 1, 0, "R2");
    step(10'h200, 0, 0, 1, 0, "R2");
    // R3: word changed after the falling sample point
    step_split(10'h155, 10'h0F0, 10'h0F0);
    step(10'h11C, 0, 0, 1, 0, "R3");
    edge_rise_i = 1'b0;
    step(10'h0C3, 0, 0, 1, 0, "R3");
    step_split(10'h1E1, 10'h333, 10'h1E1);
    step(10'h2D2, 0, 0, 1, 0, "R3");
    edge_rise_i = 1'b1;
    step(10'h04B, 0, 0, 1, 0, "R3");

    // R4: four-period request is ignored
    for (int i = 0; i < 10; i++) step(10'h300 + 10'(i), i < 4, 0, 1, 0, "R4");
    // R4/R5: long request on line A; frame j=i+1 is sync for 5..20
    for (int i = 0; i < 26; i++)
      step(10'h100 + 10'(i), i < 20, 0, 1, (i + 1 >= 5) && (i + 1 <= 20), "R5");
    // R5: exactly five periods on line B; burst is SYNC_MIN symbols, frames 5..12
    for (int i = 0; i < 16; i++)
      step(10'h080 + 10'(i), 0, i < 5, 1, (i + 1 >= 5) && (i + 1 <= 12), "R5");

    // R8: enable dropped for frames 10..12 in the middle of a burst (sync 5..24)
    for (int i = 0; i < 28; i++) begin
      bit off_next;
      off_next = (i + 1 >= 10) && (i + 1 <= 12);
      step(10'h040 + 10'(i), i < 24, 0, !off_next, (i + 1 >= 5) && (i + 1 <= 24), "R8");
      oe_i = !((i >= 10) && (i <= 12));
      if (!oe_i) begin
        #1;
        chk(!drv_en_o && !ser_o, "R8", "drive while disabled", {drv_en_o, ser_o}, 0);
      end
    end
    oe_i = 1'b1;
    drain();

    // R7: power-down and relock
    pwr_on_i = 1'b0;
    repeat (5) @(negedge clk_i);
    chk(!ready_o, "R7", "ready in power-down", ready_o, 0);
    chk(!drv_en_o && !ser_o, "R7", "drive in power-down", {drv_en_o, ser_o}, 0);
    pwr_on_i = 1'b1;
    lock_wait("R7");
    step(10'h0AA, 0, 0, 1, 0, "R7");
    step(10'h355, 0, 0, 1, 0, "R7");
    drain();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule